// File: doc/BRIEF.md
# Idle Poll Sleep Backoff Controller

This per-core controller watches the outcome of every receive poll made by a busy-polling packet loop. Each poll arrives as a one-cycle strobe carrying the number of packets the poll returned. The controller keeps two counters. The first is the length of the current run of empty polls. The second is a backoff count that only starts to advance once that run is long enough. From the backoff count it derives a requested sleep length in microseconds and a hint for how deep an idle state the core may enter.

The sleep length first grows by one microsecond per further empty poll. It then holds at a short plateau tied to a light idle state, and finally at a longer plateau tied to a deep idle state. Any poll that returns traffic brings the controller straight back to full-speed polling. A saturating accumulator adds up the sleep granted on each poll and is cleared by a window-end strobe, so other logic can read the sleep time per evaluation window. The block does not time the sleep and does not enter any power state.

Top module: `idle_backoff_ctrl`

## Requirements
- R1: After reset, sleep_req is 0, sleep_us is 0, cstate_hint is 0 and accum_us is 0.
- R2: While fewer than 5 consecutive empty polls have been seen, sleep_req stays 0 and sleep_us stays 0.
- R3: The backoff count stays at 0 through the fifth consecutive empty poll. Each further empty poll adds one to it. While the count is 1 to 99, sleep_us equals the count, sleep_req is 1 and cstate_hint is 0. Outputs update on the clock edge that takes the poll strobe.
- R4: While the backoff count is 100 to 999, sleep_us is 100 and cstate_hint is 1 (the C1 class).
- R5: While the backoff count is 1000 or more, sleep_us is 500 and cstate_hint is 2 (the C3 class).
- R6: A poll with poll_pkts nonzero clears both the backoff count and the empty run. Outputs return to sleep_req 0, sleep_us 0 and hint 0, and 5 more empty polls are then needed before the count moves again.
- R7: In cycles without a poll strobe, sleep_req, sleep_us and cstate_hint do not change. accum_us changes only on a poll strobe or on win_end.
- R8: The backoff count saturates at 4095 (CNT_W of 12) and does not wrap. Further empty polls keep sleep_us at 500 and the hint at 2.
- R9: On each poll strobe, accum_us adds the sleep_us value produced by that poll, saturating at 2^24-1. win_end clears it. When win_end and a poll strobe come in the same cycle, the window restarts holding only that poll's sleep value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| poll_valid | input | 1 | One-cycle strobe: a poll completed |
| poll_pkts | input | 8 | Packets returned by that poll |
| win_end | input | 1 | Ends the evaluation window; clears the accumulator |
| sleep_req | output | 1 | A sleep is requested |
| sleep_us | output | 10 | Requested sleep length in microseconds |
| cstate_hint | output | 2 | 0 none, 1 light (C1), 2 deep (C3) |
| accum_us | output | 24 | Sleep microseconds granted in the current window |

## Verification
Long directed empty runs walk the backoff count across each boundary: the fifth and sixth empty polls, counts 99 and 100, counts 999 and 1000, and the saturation point at 4095. These runs tell apart an off-by-one in the start threshold, in the ramp and in each plateau edge. Single packet-bearing polls dropped into runs of different lengths show whether the run length is cleared as well as the count. Idle gaps between strobes show whether the state moves without a poll. Random mixes of mostly empty polls with sparse traffic and window-end strobes, some landing on a poll cycle, exercise the accumulator's add, clear and restart orderings against the bench model.

// File: rtl/idle_backoff_pkg.sv
package idle_backoff_pkg;

  typedef enum logic [1:0] {
    HINT_NONE  = 2'd0,
    HINT_LIGHT = 2'd1,
    HINT_DEEP  = 2'd2
  } hint_e;

  // Sleep length for a given backoff count.
  function automatic int unsigned backoff_len(
    input int unsigned cnt,
    input int unsigned lin_end,
    input int unsigned deep_at,
    input int unsigned light_us,
    input int unsigned deep_us
  );
    if (cnt < lin_end)      return cnt;
    else if (cnt < deep_at) return light_us;
    else                    return deep_us;
  endfunction

  // Idle-depth hint for a given backoff count.
  function automatic hint_e backoff_hint(
    input int unsigned cnt,
    input int unsigned lin_end,
    input int unsigned deep_at
  );
    if (cnt < lin_end)      return HINT_NONE;
    else if (cnt < deep_at) return HINT_LIGHT;
    else                    return HINT_DEEP;
  endfunction

endpackage

// File: rtl/backoff_run_tracker.sv
module backoff_run_tracker #(
  parameter int PKT_W     = 8,
  parameter int CNT_W     = 12,
  parameter int START_RUN = 5,
  localparam int RUN_W    = $clog2(START_RUN + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             poll_valid,
  input  logic [PKT_W-1:0] poll_pkts,
  output logic [RUN_W-1:0] run_q,
  output logic [CNT_W-1:0] cnt_q,
  output logic [CNT_W-1:0] cnt_d
);

  localparam logic [RUN_W-1:0] RUN_FULL = RUN_W'(START_RUN);
  localparam logic [CNT_W-1:0] CNT_MAX  = '1;

  logic [RUN_W-1:0] run_d;
  logic             pkts_seen;

  assign pkts_seen = (poll_pkts != '0);

  // Next state: run length grows to START_RUN, then the count ramps.
  always_comb begin
    run_d = run_q;
    cnt_d = cnt_q;
    if (poll_valid) begin
      if (pkts_seen) begin
        run_d = '0;
        cnt_d = '0;
      end else if (run_q != RUN_FULL) begin
        run_d = run_q + 1'b1;
      end else if (cnt_q != CNT_MAX) begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= '0;
      cnt_q <= '0;
    end else if (poll_valid) begin
      run_q <= run_d;
      cnt_q <= cnt_d;
    end
  end

endmodule

// File: rtl/backoff_sleep_map.sv
module backoff_sleep_map
  import idle_backoff_pkg::*;
#(
  parameter int CNT_W    = 12,
  parameter int US_W     = 10,
  parameter int LIN_END  = 100,
  parameter int DEEP_AT  = 1000,
  parameter int LIGHT_US = 100,
  parameter int DEEP_US  = 500
) (
  input  logic [CNT_W-1:0] cnt,
  output logic             req,
  output logic [US_W-1:0]  us,
  output logic [1:0]       hint
);

  int unsigned len_w;
  hint_e       hint_w;

  always_comb begin
    len_w  = backoff_len(32'(cnt), LIN_END, DEEP_AT, LIGHT_US, DEEP_US);
    hint_w = backoff_hint(32'(cnt), LIN_END, DEEP_AT);
    us     = US_W'(len_w);
    hint   = hint_w;
    req    = (cnt != '0);
  end

endmodule

// File: rtl/backoff_sleep_accum.sv
module backoff_sleep_accum
  import idle_backoff_pkg::*;
#(
  parameter int CNT_W    = 12,
  parameter int US_W     = 10,
  parameter int ACC_W    = 24,
  parameter int LIN_END  = 100,
  parameter int DEEP_AT  = 1000,
  parameter int LIGHT_US = 100,
  parameter int DEEP_US  = 500
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             poll_valid,
  input  logic             win_end,
  input  logic [CNT_W-1:0] cnt_next,
  output logic [ACC_W-1:0] acc_q
);

  logic [ACC_W-1:0] acc_d;
  logic [ACC_W-1:0] base;
  logic [ACC_W:0]   sum;
  logic [US_W-1:0]  add_us;
  logic             acc_en;

  assign acc_en = poll_valid | win_end;

  // The sleep granted by this poll is the one for the updated count.
  always_comb begin
    add_us = US_W'(backoff_len(32'(cnt_next), LIN_END, DEEP_AT, LIGHT_US, DEEP_US));
    base   = win_end ? '0 : acc_q;
    sum    = {1'b0, base} + (ACC_W + 1)'(add_us);
    if (!poll_valid)   acc_d = base;
    else if (sum[ACC_W]) acc_d = '1;
    else               acc_d = sum[ACC_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      acc_q <= '0;
    else if (acc_en) acc_q <= acc_d;
  end

endmodule

// File: rtl/idle_backoff_ctrl.sv
module idle_backoff_ctrl #(
  parameter int PKT_W     = 8,
  parameter int CNT_W     = 12,
  parameter int US_W      = 10,
  parameter int ACC_W     = 24,
  parameter int START_RUN = 5,
  parameter int LIN_END   = 100,
  parameter int DEEP_AT   = 1000,
  parameter int LIGHT_US  = 100,
  parameter int DEEP_US   = 500
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             poll_valid,
  input  logic [PKT_W-1:0] poll_pkts,
  input  logic             win_end,
  output logic             sleep_req,
  output logic [US_W-1:0]  sleep_us,
  output logic [1:0]       cstate_hint,
  output logic [ACC_W-1:0] accum_us
);

  localparam int RUN_W = $clog2(START_RUN + 1);

  logic [RUN_W-1:0] run_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;

  backoff_run_tracker #(
    .PKT_W(PKT_W), .CNT_W(CNT_W), .START_RUN(START_RUN)
  ) u_track (
    .clk(clk), .rst_n(rst_n), .poll_valid(poll_valid), .poll_pkts(poll_pkts),
    .run_q(run_q), .cnt_q(cnt_q), .cnt_d(cnt_d)
  );

  backoff_sleep_map #(
    .CNT_W(CNT_W), .US_W(US_W), .LIN_END(LIN_END), .DEEP_AT(DEEP_AT),
    .LIGHT_US(LIGHT_US), .DEEP_US(DEEP_US)
  ) u_map (
    .cnt(cnt_q), .req(sleep_req), .us(sleep_us), .hint(cstate_hint)
  );

  backoff_sleep_accum #(
    .CNT_W(CNT_W), .US_W(US_W), .ACC_W(ACC_W), .LIN_END(LIN_END),
    .DEEP_AT(DEEP_AT), .LIGHT_US(LIGHT_US), .DEEP_US(DEEP_US)
  ) u_acc (
    .clk(clk), .rst_n(rst_n), .poll_valid(poll_valid), .win_end(win_end),
    .cnt_next(cnt_d), .acc_q(accum_us)
  );

endmodule

// File: rtl/idle_backoff_chk.sv
module idle_backoff_chk #(
  parameter int PKT_W     = 8,
  parameter int CNT_W     = 12,
  parameter int US_W      = 10,
  parameter int ACC_W     = 24,
  parameter int START_RUN = 5,
  parameter int DEEP_AT   = 1000,
  parameter int DEEP_US   = 500,
  localparam int RUN_W    = $clog2(START_RUN + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             poll_valid,
  input logic [PKT_W-1:0] poll_pkts,
  input logic             win_end,
  input logic             sleep_req,
  input logic [US_W-1:0]  sleep_us,
  input logic [1:0]       cstate_hint,
  input logic [ACC_W-1:0] accum_us,
  input logic [RUN_W-1:0] run_q,
  input logic [CNT_W-1:0] cnt_q
);

  localparam logic [CNT_W-1:0] CMAX = '1;

  a_r2_no_early_sleep: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q < RUN_W'(START_RUN)) |-> (!sleep_req && sleep_us == '0));

  a_r3_step_one: assert property (@(posedge clk) disable iff (!rst_n)
    (poll_valid && poll_pkts == '0 && run_q == RUN_W'(START_RUN) && cnt_q != CMAX)
      |=> (cnt_q == $past(cnt_q) + 1'b1));

  a_r5_deep_plateau: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q >= CNT_W'(DEEP_AT)) |-> (sleep_us == US_W'(DEEP_US) && cstate_hint == 2'd2));

  a_r6_traffic_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (poll_valid && poll_pkts != '0) |=> (!sleep_req && run_q == '0 && cnt_q == '0));

  a_r7_hold_no_poll: assert property (@(posedge clk) disable iff (!rst_n)
    !poll_valid |=> ($stable(sleep_us) && $stable(cstate_hint) && $stable(sleep_req)));

  a_r8_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (poll_valid && poll_pkts == '0 && cnt_q == CMAX) |=> (cnt_q == CMAX));

  a_r9_window_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (win_end && !poll_valid) |=> (accum_us == '0));

endmodule

bind idle_backoff_ctrl idle_backoff_chk #(
  .PKT_W(PKT_W), .CNT_W(CNT_W), .US_W(US_W), .ACC_W(ACC_W),
  .START_RUN(START_RUN), .DEEP_AT(DEEP_AT), .DEEP_US(DEEP_US)
) u_chk (
  .clk(clk), .rst_n(rst_n), .poll_valid(poll_valid), .poll_pkts(poll_pkts),
  .win_end(win_end), .sleep_req(sleep_req), .sleep_us(sleep_us),
  .cstate_hint(cstate_hint), .accum_us(accum_us), .run_q(run_q), .cnt_q(cnt_q)
);

// File: tb/idle_backoff_ctrl_test.sv
module idle_backoff_ctrl_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        poll_valid = 1'b0;
  logic [7:0]  poll_pkts = '0;
  logic        win_end = 1'b0;
  logic        sleep_req;
  logic [9:0]  sleep_us;
  logic [1:0]  cstate_hint;
  logic [23:0] accum_us;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  // Bench model
  int m_run = 0;
  int m_cnt = 0;
  longint m_acc = 0;

  always #5 clk = ~clk;

  idle_backoff_ctrl uut (
    .clk(clk), .rst_n(rst_n), .poll_valid(poll_valid), .poll_pkts(poll_pkts),
    .win_end(win_end), .sleep_req(sleep_req), .sleep_us(sleep_us),
    .cstate_hint(cstate_hint), .accum_us(accum_us)
  );

  function automatic int exp_us(int c);
    if (c < 100) return c;
    else if (c < 1000) return 100;
    else return 500;
  endfunction

  function automatic int exp_hint(int c);
    if (c < 100) return 0;
    else if (c < 1000) return 1;
    else return 2;
  endfunction

  task automatic check(string tag);
    int eu, eh, er;
    eu = exp_us(m_cnt);
    eh = exp_hint(m_cnt);
    er = (m_cnt != 0) ? 1 : 0;
    n_cmp++;
    if (int'(sleep_us) != eu || int'(cstate_hint) != eh || int'(sleep_req) != er ||
        longint'(accum_us) != m_acc) begin
      n_bad++;
      $display("FAIL %s: got us=%0d hint=%0d req=%0d acc=%0d, expected us=%0d hint=%0d req=%0d acc=%0d",
               tag, sleep_us, cstate_hint, sleep_req, accum_us, eu, eh, er, m_acc);
    end
  endtask

  task automatic step(bit pv, int pk, bit we);
    @(negedge clk);
    poll_valid = pv;
    poll_pkts  = 8'(pk);
    win_end    = we;
    @(negedge clk);
    poll_valid = 1'b0;
    poll_pkts  = '0;
    win_end    = 1'b0;
    if (pv) begin
      if (pk != 0) begin m_run = 0; m_cnt = 0; end
      else if (m_run < 5) m_run++;
      else if (m_cnt < 4095) m_cnt++;
    end
    if (we) m_acc = 0;
    if (pv) begin
      m_acc += exp_us(m_cnt);
      if (m_acc > 64'hFFFFFF) m_acc = 64'hFFFFFF;
    end
  endtask

  task automatic empties(int n);
    for (int i = 0; i < n; i++) step(1'b1, 0, 1'b0);
  endtask

  initial begin
    #1_500_000;
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: got hung run, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = 32'h5eed_1234;
    void'($urandom(seed));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 reset state");

    empties(4);            check("R2 four empties, no sleep");
    step(1'b1, 0, 1'b0);   check("R2 fifth empty, count still zero");
    step(1'b1, 0, 1'b0);   check("R3 sixth empty, count one");
    repeat (4) step(1'b0, 0, 1'b0);
    check("R7 idle cycles hold outputs");
    empties(97);           check("R3 count 98");
    step(1'b1, 0, 1'b0);   check("R3 count 99 last ramp value");
    step(1'b1, 0, 1'b0);   check("R4 count 100 light plateau");
    empties(899);          check("R4 count 999");
    step(1'b1, 0, 1'b0);   check("R5 count 1000 deep plateau");
    step(1'b0, 0, 1'b1);   check("R9 window end clears accumulator");
    step(1'b1, 0, 1'b1);   check("R9 window end with poll restarts at that sleep");
    step(1'b1, 3, 1'b0);   check("R6 traffic poll clears");
    empties(5);            check("R6 five empties needed again");
    step(1'b1, 0, 1'b0);   check("R6 count resumes after restart");
    empties(3);
    step(1'b1, 1, 1'b0);   check("R6 clear mid ramp");
    empties(2);
    step(1'b1, 0, 1'b0);   check("R6 short run after clear gives no sleep");
    empties(4200);         check("R8 saturated count stays deep");
    step(1'b1, 0, 1'b0);   check("R8 no wrap past maximum");
    step(1'b0, 0, 1'b1);   check("R9 clear after saturation run");

    // Random mix: mostly empty polls, sparse traffic, occasional window ends.
    for (int i = 0; i < 3000; i++) begin
      bit pv, we;
      int pk;
      pv = ($urandom_range(0, 9) != 0);
      pk = ($urandom_range(0, 99) < 3) ? int'($urandom_range(1, 255)) : 0;
      we = ($urandom_range(0, 99) < 2);
      step(pv, pk, we);
      check("R3/R4/R5/R9 random mix");
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule